// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block generates two independent pulse-width-modulated outputs. Software reaches it through a plain 32-bit register bus: one shared control word and one period word per channel. For each channel, the input clock first passes through a divider whose ratio comes from a fixed table indexed by a 4-bit code. An 8-bit counter then runs on the divided ticks. The output is asserted while the count is below a programmed active length, and the level it is asserted at depends on a per-channel polarity bit.

Software changes a period word in one of two ways. It can stop the channel's clock gate and write the word, or it can write it while the channel runs. In the second case the new value is held back and applied when the counter next wraps. A per-channel ready flag in the control word shows that a held-back value is still pending.

Top module: `pwm_dual_ctl`

## Requirements
- R1: After reset every register reads 0 and both outputs are 1, because polarity 0 means inverted output and its inactive level is high.
- R2: The control word is at byte address 0x0, channel 0's period word at 0x4 and channel 1's at 0x8. In the control word, channel 0 uses bits [3:0] for the prescale code, bit 4 for enable, bit 5 for polarity and bit 6 for the clock gate. Bits 7, 8 and 9 are spare mode bits that are stored and read back but have no effect on the output. Channel 1 uses the same layout shifted up by 15 bits.
- R3: Control bits 14:10, 27:25, 31 and 30 always read 0. The ready bits 28 (channel 0) and 29 (channel 1) are read-only, and writes to them are ignored.
- R4: The prescale code selects the division ratio: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, 15→1. With period 2 and active length 1, the output stays active for exactly one ratio's worth of clock cycles after it is enabled.
- R5: Codes 5, 6, 7, 13 and 14 are invalid. They stop the channel's ticks and hold the output at its inactive level.
- R6: The period word holds the active length in bits 7:0 and the period in bits 23:16. The counter runs from 0 to period−1 and wraps, and the output is active while count < active length. A period of 0 behaves as a period of 1.
- R7: An active length of 0 gives a constant inactive output. An active length ≥ period gives a constant active output.
- R8: With polarity 1 the active level is 1. With polarity 0 the output is the inverse.
- R9: A channel drives its pulse only while both enable and gate are 1. With enable set and the gate cleared, the output is inactive and the counter is frozen. When the gate is set again, counting resumes from the frozen count.
- R10: Clearing enable resets the counter and prescaler to 0 and drives the output to its inactive level. After it is enabled again, the first period starts at count 0.
- R11: A period write to a running channel is staged and sets that channel's ready flag. The live value, which is what the register reads back, is replaced on the cycle the counter wraps, and the flag clears on that same cycle.
- R12: A period write that arrives while the channel's ready flag is set is ignored, including a write on the wrap cycle itself.
- R13: A period write to a channel that is not running (not enabled, gate cleared, or invalid code) takes effect at once, and its ready flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 2 | PWM outputs, bit N is channel N |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 4-bit address.

The divide-by-one code makes every counter cycle visible on the output. This lets the bench sweep every active length from 0 to period+1 over periods 0, 1, 2, 3 and 5, in both polarities and on both channels, and compare each sampled level against an arithmetic model.

The short ratios and the two smallest long ratios are measured directly as pulse widths. Every invalid code is checked for a held inactive output. The gate-freeze, disable-reset, staged-update and write-while-pending orderings are driven with cycle-exact timing.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NCH       = 2;
  localparam int CH_STRIDE = 15;
  localparam int FLD_W     = 10;
  localparam int RDY_LSB   = 28;
  localparam int PRD_LSB   = 16;
  localparam int PSC_W     = 17;

  // packed from msb: field bit 9 down to bit 0
  typedef struct packed {
    logic       spare_c;
    logic       spare_b;
    logic       spare_a;
    logic       gate;
    logic       pol;
    logic       en;
    logic [3:0] code;
  } ch_ctrl_t;

  // 0 marks an invalid code
  function automatic logic [PSC_W-1:0] psc_ratio(input logic [3:0] code);
    case (code)
      4'd0:    return PSC_W'(120);
      4'd1:    return PSC_W'(180);
      4'd2:    return PSC_W'(240);
      4'd3:    return PSC_W'(360);
      4'd4:    return PSC_W'(480);
      4'd8:    return PSC_W'(12000);
      4'd9:    return PSC_W'(24000);
      4'd10:   return PSC_W'(36000);
      4'd11:   return PSC_W'(48000);
      4'd12:   return PSC_W'(72000);
      4'd15:   return PSC_W'(1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [3:0] code_i,
  output logic       tick_o,
  output logic       ok_o
);
  logic [PSC_W-1:0] ratio;
  logic [PSC_W-1:0] pc_q;

  assign ratio  = psc_ratio(code_i);
  assign ok_o   = (ratio != '0);
  // >= keeps a mid-count ratio change from running the counter to its top
  assign tick_o = run_i && ok_o && (pc_q >= ratio - PSC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (clr_i)             pc_q <= '0;
    else if (tick_o)            pc_q <= '0;
    else if (run_i && ok_o)     pc_q <= pc_q + PSC_W'(1);
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wact_i,
  input  logic [CNT_W-1:0] wprd_i,
  output logic [CNT_W-1:0] act_o,
  output logic [CNT_W-1:0] prd_o,
  output logic             busy_o,
  output logic             on_o
);
  logic [CNT_W-1:0] cnt_q, act_q, prd_q, sact_q, sprd_q;
  logic             busy_q;
  logic             wrap;

  // period 0 wraps on every tick, same as period 1
  assign wrap = tick_i && (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, prd_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      prd_q  <= '0;
      sact_q <= '0;
      sprd_q <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      // pending value lands at the wrap, or at once if the channel stops
      if (wrap || !run_i) begin
        act_q  <= sact_q;
        prd_q  <= sprd_q;
        busy_q <= 1'b0;
      end
    end else if (wr_i) begin
      if (run_i) begin
        sact_q <= wact_i;
        sprd_q <= wprd_i;
        busy_q <= 1'b1;
      end else begin
        act_q <= wact_i;
        prd_q <= wprd_i;
      end
    end
  end

  assign act_o  = act_q;
  assign prd_o  = prd_q;
  assign busy_o = busy_q;
  assign on_o   = run_i && (cnt_q < act_q);
endmodule

// File: rtl/pwm_dual_ctl.sv
module pwm_dual_ctl
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic [NCH-1:0]            en_w, gate_w, pol_w, busy_w, run_w, ok_w, tick_w, on_w, pwr_w;
  logic [NCH-1:0][3:0]       code_w;
  logic [NCH-1:0][FLD_W-1:0] fld_w;
  logic [NCH-1:0][CNT_W-1:0] act_w, prd_w;
  logic                      ctrl_wr;
  logic [31:0]               ctrl_rd;
  logic                      unused_wdata;

  assign ctrl_wr      = wr_en_i && (addr_i == CTRL_ADDR);
  assign unused_wdata = ^wdata_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(4 * (c + 1));
    ch_ctrl_t cq;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cq <= '0;
      else if (ctrl_wr) cq <= ch_ctrl_t'(wdata_i[c*CH_STRIDE +: FLD_W]);
    end

    assign fld_w[c]  = cq;
    assign en_w[c]   = cq.en;
    assign gate_w[c] = cq.gate;
    assign pol_w[c]  = cq.pol;
    assign code_w[c] = cq.code;
    assign pwr_w[c]  = wr_en_i && (addr_i == PADDR);
    assign run_w[c]  = en_w[c] && gate_w[c] && ok_w[c];

    pwm_prescaler u_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!en_w[c]),
      .run_i  (en_w[c] && gate_w[c]),
      .code_i (code_w[c]),
      .tick_o (tick_w[c]),
      .ok_o   (ok_w[c])
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!en_w[c]),
      .run_i  (run_w[c]),
      .tick_i (tick_w[c]),
      .wr_i   (pwr_w[c]),
      .wact_i (wdata_i[CNT_W-1:0]),
      .wprd_i (wdata_i[PRD_LSB +: CNT_W]),
      .act_o  (act_w[c]),
      .prd_o  (prd_w[c]),
      .busy_o (busy_w[c]),
      .on_o   (on_w[c])
    );

    assign pwm_o[c] = on_w[c] ? pol_w[c] : !pol_w[c];
  end

  always_comb begin
    ctrl_rd = '0;
    for (int c = 0; c < NCH; c++) begin
      ctrl_rd[c*CH_STRIDE +: FLD_W] = fld_w[c];
      ctrl_rd[RDY_LSB + c]          = busy_w[c];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) rdata_o = ctrl_rd;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == ADDR_W'(4 * (c + 1))) begin
        rdata_o[CNT_W-1:0]         = act_w[c];
        rdata_o[PRD_LSB +: CNT_W]  = prd_w[c];
      end
    end
  end
endmodule

// File: rtl/pwm_dual_ctl_chk.sv
module pwm_dual_ctl_chk
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic [NCH-1:0]    pwm_o,
  input logic [NCH-1:0]    en_i,
  input logic [NCH-1:0]    gate_i,
  input logic [NCH-1:0]    pol_i,
  input logic [NCH-1:0][3:0] code_i,
  input logic [NCH-1:0]    busy_i
);
  // R3
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (rdata_o[31:30] == 2'b0 && rdata_o[27:25] == 3'b0 && rdata_o[14:10] == 5'b0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R10
    dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[c] |-> (pwm_o[c] == !pol_i[c]));
    // R9
    gate_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_i[c] |-> (pwm_o[c] == !pol_i[c]));
    // R5
    bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (psc_ratio(code_i[c]) == '0) |-> (pwm_o[c] == !pol_i[c]));
    // R11
    rdy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_i[c]) |-> $past(wr_en_i && addr_i == ADDR_W'(4 * (c + 1))));
  end
endmodule

bind pwm_dual_ctl pwm_dual_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .pwm_o   (pwm_o),
  .en_i    (en_w),
  .gate_i  (gate_w),
  .pol_i   (pol_w),
  .code_i  (code_w),
  .busy_i  (busy_w)
);

// File: tb/sim_pwm_dual_ctl.sv
module sim_pwm_dual_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_dual_ctl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  function automatic logic [31:0] cw(input int ch, input logic [3:0] code, input logic en,
                                     input logic pol, input logic gate, input logic [2:0] spare);
    logic [9:0] f;
    f = {spare, gate, pol, en, code};
    return 32'(f) << (15 * ch);
  endfunction

  function automatic logic [31:0] pw(input int prd, input int act);
    return (32'(prd) << 16) | 32'(act);
  endfunction

  // R6 R7 R8: sweep with divide-by-one
  task automatic sweep(input int ch, input int prd, input int act, input logic pol, input logic [2:0] spare);
    int eff;
    logic e;
    eff = (prd == 0) ? 1 : prd;
    wr(4'h0, 32'h0);
    wr(4'(4 * (ch + 1)), pw(prd, act));
    wr(4'h0, cw(ch, 4'd15, 1'b1, pol, 1'b1, spare));
    for (int i = 0; i < 2 * eff + 3; i++) begin
      e = ((i % eff) < act) ? pol : !pol;
      chk(act == 0 ? "R7 zero-active" : (act >= eff ? "R7 full-active" : "R6 R8 wave"),
          32'(pwm_o[ch]), 32'(e));
      chk("R2 other channel idle", 32'(pwm_o[1-ch]), 32'd1);
      @(negedge clk_i);
    end
  endtask

  task automatic meas(input logic [3:0] code, input int div);
    int cnt;
    wr(4'h0, 32'h0);
    wr(4'h4, pw(2, 1));
    wr(4'h0, cw(0, code, 1'b1, 1'b1, 1'b1, 3'b0));
    cnt = 0;
    while (pwm_o[0] == 1'b1 && cnt < 100000) begin
      cnt++;
      @(negedge clk_i);
    end
    chk("R4 ratio", 32'(cnt), 32'(div));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int exp_seq[5];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'h4, d); chk("R1 per0", d, 32'h0);
    rd(4'h8, d); chk("R1 per1", d, 32'h0);
    chk("R1 outputs", 32'(pwm_o), 32'h3);

    // R2 R3: layout and reserved/read-only bits
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 R3 ctrl readback", d, 32'h01FF_83FF);
    wr(4'h0, 32'h0);

    // R13: write while stopped lands at once
    wr(4'h8, pw(9, 5));
    rd(4'h8, d); chk("R13 per1 direct", d, pw(9, 5));
    rd(4'h0, d); chk("R13 no ready", d, 32'h0);

    for (int ch = 0; ch < 2; ch++)
      foreach (exp_seq[k]) begin
        int prd;
        prd = (k == 4) ? 5 : k;
        for (int act = 0; act <= prd + 1; act++)
          for (int p = 0; p < 2; p++)
            sweep(ch, prd, act, p[0], 3'b000);
      end
    // R2: spare mode bits have no effect
    sweep(0, 3, 1, 1'b1, 3'b111);
    sweep(1, 3, 2, 1'b0, 3'b111);

    // R4
    meas(4'd15, 1);
    meas(4'd0, 120);
    meas(4'd1, 180);
    meas(4'd2, 240);
    meas(4'd3, 360);
    meas(4'd4, 480);
    meas(4'd8, 12000);
    meas(4'd9, 24000);

    // R5
    foreach (exp_seq[k]) begin
      logic [3:0] bad;
      bad = (k < 3) ? 4'(5 + k) : 4'(10 + k);
      wr(4'h0, 32'h0);
      wr(4'h4, pw(4, 4));
      wr(4'h0, cw(0, bad, 1'b1, 1'b1, 1'b1, 3'b0));
      chk("R5 invalid code idle", 32'(pwm_o[0]), 32'd0);
      repeat (20) @(negedge clk_i);
      chk("R5 invalid code held", 32'(pwm_o[0]), 32'd0);
    end

    // R11 R12
    wr(4'h0, 32'h0);
    wr(4'h4, pw(4, 2));
    wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1, 3'b0));
    wr(4'h4, pw(6, 3));
    rd(4'h0, d); chk("R11 ready set", 32'(d[28]), 32'd1);
    rd(4'h4, d); chk("R11 old value live", d, pw(4, 2));
    wr(4'h4, pw(7, 1));
    rd(4'h0, d); chk("R11 ready cleared at wrap", 32'(d[28]), 32'd0);
    rd(4'h4, d); chk("R12 pending write dropped", d, pw(6, 3));
    for (int i = 0; i < 12; i++) begin
      chk("R11 new period", 32'(pwm_o[0]), 32'((i % 6) < 3));
      @(negedge clk_i);
    end

    // R9
    wr(4'h0, 32'h0);
    wr(4'h4, pw(8, 4));
    wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1, 3'b0));
    repeat (2) @(negedge clk_i);
    wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b0, 3'b0));
    chk("R9 gate off idle", 32'(pwm_o[0]), 32'd0);
    repeat (5) @(negedge clk_i);
    chk("R9 gate off held", 32'(pwm_o[0]), 32'd0);
    wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1, 3'b0));
    exp_seq = '{0, 0, 0, 0, 1};
    for (int i = 0; i < 5; i++) begin
      chk("R9 resume from frozen count", 32'(pwm_o[0]), 32'(exp_seq[i]));
      @(negedge clk_i);
    end

    // R10
    wr(4'h0, cw(0, 4'd15, 1'b0, 1'b1, 1'b1, 3'b0));
    chk("R10 disabled idle", 32'(pwm_o[0]), 32'd0);
    wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1, 3'b0));
    exp_seq = '{1, 1, 1, 1, 0};
    for (int i = 0; i < 5; i++) begin
      chk("R10 restart from zero", 32'(pwm_o[0]), 32'(exp_seq[i]));
      @(negedge clk_i);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule